// File: doc/BRIEF.md
# Instruction Queue Doorbell and Error Control

This block is the per-queue control logic in front of a command-queue coprocessor. Software tells the queue how much work is waiting by writing a word count into a doorbell register. The block adds that count to a pending total. It asks the fetch path for an instruction while the queue is on and at least one whole 8-word instruction is pending. Each fetch pulse that comes back removes one instruction's worth of words from the total.

The block also keeps the queue enable bit, a five-bit sticky cause register and a matching interrupt enable register. The fetch path, the result path, the engines, the doorbell adder and a mailbox write all report events into the cause register as single-cycle pulses. Three of the causes are fatal to the queue: doorbell overflow, instruction read error and result write error. When one of them is raised, the block turns the queue off on its own unless a continue-on-error bit is set.

Overflow wraps the count, so software can recover in a known way. It disables the queue, writes the two's-complement of the count so that the total returns to zero, and then clears the cause.

Top module: `iq_doorbell_ctl`

## Requirements
- R1: After a synchronous reset, the following are all zero: the queue enable, continue-on-error, the pending count, the causes, the interrupt enables, `rd_data`, `irq` and `fetch_req`.
- R2: A write to address 1 adds `reg_wdata` (a count of 64-bit words) to the pending count. A read of address 1 returns the count.
- R3: Address 0 is the control register: bit 0 is queue enable and bit 1 is continue-on-error. `fetch_req` is high exactly while the queue is enabled and the count is at least 8. A `fetch_pulse` taken while `fetch_req` is high subtracts 8. A `fetch_pulse` is ignored while `fetch_req` is low. A doorbell write and a fetch in the same cycle both take effect.
- R4: If an add carries out of the count width, cause bit 1 is set and the count wraps modulo 2^CNT_W. Writing 2^CNT_W minus the count therefore returns it to zero.
- R5: The cause bits are: bit 0 mailbox, bit 1 doorbell overflow, bit 2 instruction read error (`rd_err_pulse`), bit 3 result write error (`wr_err_pulse`), bit 4 engine software error (`eng_err_pulse`). Each cause is sticky. Address 2 clears the bits written as one, and address 3 sets the bits written as one. A read of either address returns the causes.
- R6: The interrupt enables use the same bit positions. Address 4 sets the bits written as one, and address 5 clears them. A read of either address returns the enables.
- R7: With continue-on-error at 0, setting cause bit 1, 2 or 3, by hardware or through address 3, clears the queue enable on the same clock edge. Setting bit 0 or bit 4 leaves the queue enable unchanged.
- R8: With continue-on-error at 1, all causes are still recorded, but the queue enable is left unchanged.
- R9: Any write to address 6 (the first mailbox word) sets cause bit 0.
- R10: `irq` is high whenever any cause bit and its enable bit are both set, and it stays high until that condition ends.
- R11: If a hardware event and a software clear hit the same cause bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | CNT_W | Write data |
| rd_data | output | CNT_W | Read data, registered, valid the cycle after `reg_rd` |
| fetch_pulse | input | 1 | One instruction has been fetched |
| rd_err_pulse | input | 1 | Instruction read error event |
| wr_err_pulse | input | 1 | Result write error event |
| eng_err_pulse | input | 1 | Engine software error event |
| fetch_req | output | 1 | Queue may fetch an instruction |
| q_enable | output | 1 | Queue enable state |
| irq | output | 1 | Level interrupt |

## Verification
Every register write and every event pulse updates the state on the clock edge where it is sampled. `q_enable`, `irq` and `fetch_req` are decoded from that state, so they are correct right after that edge. A value read back through `rd_data` comes one edge later, because the read port has its own register. The bench drives all inputs on the falling edge and holds each strobe for exactly one rising edge. It compares outputs at the following falling edge, so every check lands at the cycle counted for that path. The overflow check, the same-cycle write-plus-fetch check and the hardware-versus-software-clear check each depend on two inputs arriving on the same edge, so each of those stimuli is applied within a single cycle.

// File: rtl/iqdb_pkg.sv
package iqdb_pkg;
  localparam int NCAUSE = 5;

  // cause bit positions
  localparam int C_MBOX = 0;
  localparam int C_DOVF = 1;
  localparam int C_RDERR = 2;
  localparam int C_WRERR = 3;
  localparam int C_ENGERR = 4;

  // causes that stop the queue when continue-on-error is clear
  localparam logic [NCAUSE-1:0] STOP_MASK =
    (NCAUSE'(1) << C_DOVF) | (NCAUSE'(1) << C_RDERR) | (NCAUSE'(1) << C_WRERR);

  // register addresses
  localparam logic [2:0] RA_QCTL = 3'd0;
  localparam logic [2:0] RA_DBELL = 3'd1;
  localparam logic [2:0] RA_CAUSE_CLR = 3'd2;
  localparam logic [2:0] RA_CAUSE_SET = 3'd3;
  localparam logic [2:0] RA_IEN_SET = 3'd4;
  localparam logic [2:0] RA_IEN_CLR = 3'd5;
  localparam logic [2:0] RA_MBOX = 3'd6;
endpackage

// File: rtl/iqdb_dbell_cnt.sv
module iqdb_dbell_cnt #(
  parameter int CNT_W = 20,
  parameter int INST_WORDS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             add_en,
  input  logic [CNT_W-1:0] add_val,
  input  logic             take,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf,
  output logic             has_inst
);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(INST_WORDS);

  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] cnt_n;

  always_comb begin
    sum = {1'b0, cnt} + (add_en ? {1'b0, add_val} : '0);
    ovf = add_en & sum[CNT_W];
    cnt_n = sum[CNT_W-1:0] - (take ? STEP : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_n;
  end

  assign has_inst = (cnt >= STEP);
endmodule

// File: rtl/iqdb_w1_bits.sv
module iqdb_w1_bits #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sw_set,
  input  logic [W-1:0] sw_clr,
  input  logic [W-1:0] hw_set,
  output logic [W-1:0] q
);
  // set (hardware or software) beats a software clear on each bit
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                        q[i] <= 1'b0;
      else if (hw_set[i] | sw_set[i]) q[i] <= 1'b1;
      else if (sw_clr[i])             q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/iqdb_qctl.sv
module iqdb_qctl (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic wr_ena,
  input  logic wr_cont,
  input  logic stop_evt,
  output logic ena,
  output logic cont_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ena      <= 1'b0;
      cont_err <= 1'b0;
    end else begin
      if (wr) cont_err <= wr_cont;
      if (stop_evt) ena <= 1'b0;
      else if (wr)  ena <= wr_ena;
    end
  end
endmodule

// File: rtl/iq_doorbell_ctl.sv
module iq_doorbell_ctl
  import iqdb_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter int INST_WORDS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [2:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] rd_data,
  input  logic             fetch_pulse,
  input  logic             rd_err_pulse,
  input  logic             wr_err_pulse,
  input  logic             eng_err_pulse,
  output logic             fetch_req,
  output logic             q_enable,
  output logic             irq
);
  logic [CNT_W-1:0]  dbell_cnt;
  logic              dbell_ovf, has_inst, cont_err_q, stop_evt;
  logic [NCAUSE-1:0] cause_q, ien_q, wmask;
  logic [NCAUSE-1:0] cause_set_sw, cause_clr_sw, cause_hw;
  logic [NCAUSE-1:0] ien_set, ien_clr;
  logic              wr_qctl, wr_dbell, wr_mbox;
  logic [CNT_W-1:0]  rd_next;

  assign wmask        = reg_wdata[NCAUSE-1:0];
  assign wr_qctl      = reg_wr && (reg_addr == RA_QCTL);
  assign wr_dbell     = reg_wr && (reg_addr == RA_DBELL);
  assign wr_mbox      = reg_wr && (reg_addr == RA_MBOX);
  assign cause_set_sw = (reg_wr && reg_addr == RA_CAUSE_SET) ? wmask : '0;
  assign cause_clr_sw = (reg_wr && reg_addr == RA_CAUSE_CLR) ? wmask : '0;
  assign ien_set      = (reg_wr && reg_addr == RA_IEN_SET) ? wmask : '0;
  assign ien_clr      = (reg_wr && reg_addr == RA_IEN_CLR) ? wmask : '0;

  always_comb begin
    cause_hw           = '0;
    cause_hw[C_MBOX]   = wr_mbox;
    cause_hw[C_DOVF]   = dbell_ovf;
    cause_hw[C_RDERR]  = rd_err_pulse;
    cause_hw[C_WRERR]  = wr_err_pulse;
    cause_hw[C_ENGERR] = eng_err_pulse;
  end

  assign stop_evt  = !cont_err_q && |((cause_hw | cause_set_sw) & STOP_MASK);
  assign fetch_req = q_enable && has_inst;

  iqdb_dbell_cnt #(.CNT_W(CNT_W), .INST_WORDS(INST_WORDS)) u_cnt (
    .clk(clk), .rst(rst), .add_en(wr_dbell), .add_val(reg_wdata),
    .take(fetch_pulse && fetch_req), .cnt(dbell_cnt), .ovf(dbell_ovf),
    .has_inst(has_inst)
  );

  iqdb_w1_bits #(.W(NCAUSE)) u_cause (
    .clk(clk), .rst(rst), .sw_set(cause_set_sw), .sw_clr(cause_clr_sw),
    .hw_set(cause_hw), .q(cause_q)
  );

  iqdb_w1_bits #(.W(NCAUSE)) u_ien (
    .clk(clk), .rst(rst), .sw_set(ien_set), .sw_clr(ien_clr),
    .hw_set('0), .q(ien_q)
  );

  iqdb_qctl u_qctl (
    .clk(clk), .rst(rst), .wr(wr_qctl), .wr_ena(reg_wdata[0]),
    .wr_cont(reg_wdata[1]), .stop_evt(stop_evt), .ena(q_enable),
    .cont_err(cont_err_q)
  );

  assign irq = |(cause_q & ien_q);

  always_comb begin
    rd_next = '0;
    case (reg_addr)
      RA_QCTL: begin
        rd_next[0] = q_enable;
        rd_next[1] = cont_err_q;
      end
      RA_DBELL:                  rd_next = dbell_cnt;
      RA_CAUSE_CLR, RA_CAUSE_SET: rd_next[NCAUSE-1:0] = cause_q;
      RA_IEN_SET, RA_IEN_CLR:     rd_next[NCAUSE-1:0] = ien_q;
      default:                   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (reg_rd) rd_data <= rd_next;
  end
endmodule

// File: rtl/iqdb_chk.sv
module iqdb_chk #(
  parameter int CNT_W = 20,
  parameter int INST_WORDS = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr,
  input logic [2:0]       reg_addr,
  input logic [CNT_W-1:0] reg_wdata,
  input logic             fetch_pulse,
  input logic             fetch_req,
  input logic             rd_err_pulse,
  input logic             q_enable,
  input logic             cont_err,
  input logic             irq,
  input logic [CNT_W-1:0] cnt,
  input logic [4:0]       cause
);
  logic [CNT_W:0] add_sum;
  logic           db_wr;
  assign add_sum = {1'b0, cnt} + {1'b0, reg_wdata};
  assign db_wr   = reg_wr && (reg_addr == 3'd1);

  // R4
  dovf_set_chk: assert property (@(posedge clk) disable iff (rst)
    (db_wr && add_sum[CNT_W]) |=> cause[1]);

  // R3
  fetch_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_pulse && fetch_req && !db_wr) |=> (cnt == $past(cnt) - CNT_W'(INST_WORDS)));

  // R11
  hw_prio_chk: assert property (@(posedge clk) disable iff (rst)
    rd_err_pulse |=> cause[2]);

  // R7
  err_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_err_pulse && !cont_err) |=> !q_enable);

  // R8
  cont_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_err_pulse && cont_err && q_enable && !(reg_wr && reg_addr == 3'd0)) |=> q_enable);

  // R5
  w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 3'd2 && reg_wdata[0]) |=> !cause[0]);

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (cause == 5'd0) |-> !irq);
endmodule

bind iq_doorbell_ctl iqdb_chk #(.CNT_W(CNT_W), .INST_WORDS(INST_WORDS)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .fetch_pulse(fetch_pulse), .fetch_req(fetch_req),
  .rd_err_pulse(rd_err_pulse), .q_enable(q_enable), .cont_err(cont_err_q),
  .irq(irq), .cnt(dbell_cnt), .cause(cause_q)
);

// File: tb/tb_iq_doorbell_ctl.sv
module tb_iq_doorbell_ctl;
  localparam int CNT_W = 20;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]       reg_addr = '0;
  logic [CNT_W-1:0] reg_wdata = '0;
  logic [CNT_W-1:0] rd_data;
  logic             fetch_pulse = 1'b0, rd_err_pulse = 1'b0;
  logic             wr_err_pulse = 1'b0, eng_err_pulse = 1'b0;
  logic             fetch_req, q_enable, irq;

  int nvec = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  iq_doorbell_ctl #(.CNT_W(CNT_W), .INST_WORDS(8)) dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rd_data(rd_data),
    .fetch_pulse(fetch_pulse), .rd_err_pulse(rd_err_pulse),
    .wr_err_pulse(wr_err_pulse), .eng_err_pulse(eng_err_pulse),
    .fetch_req(fetch_req), .q_enable(q_enable), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // one write, optionally with event pulses on the same edge
  task automatic wr(input logic [2:0] a, input logic [CNT_W-1:0] d,
                    input logic fp = 1'b0, input logic re = 1'b0);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    fetch_pulse = fp; rd_err_pulse = re;
    @(negedge clk);
    reg_wr = 1'b0; fetch_pulse = 1'b0; rd_err_pulse = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [CNT_W-1:0] v);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    v = rd_data;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: fetch_pulse = 1'b1;
      1: rd_err_pulse = 1'b1;
      2: wr_err_pulse = 1'b1;
      default: eng_err_pulse = 1'b1;
    endcase
    @(negedge clk);
    fetch_pulse = 1'b0; rd_err_pulse = 1'b0;
    wr_err_pulse = 1'b0; eng_err_pulse = 1'b0;
  endtask

  task automatic t_reset();
    logic [CNT_W-1:0] v;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R1 reg readback", 32'(v), 32'h0);
    end
    chk("R1 irq", 32'(irq), 0);
    chk("R1 fetch_req", 32'(fetch_req), 0);
    chk("R1 q_enable", 32'(q_enable), 0);
  endtask

  task automatic t_doorbell();
    logic [CNT_W-1:0] v;
    wr(3'd1, 20'd16);
    wr(3'd1, 20'd24);
    rd(3'd1, v); chk("R2 sum of adds", 32'(v), 40);
    chk("R3 no fetch_req while disabled", 32'(fetch_req), 0);
    pulse(0);
    rd(3'd1, v); chk("R3 fetch ignored while disabled", 32'(v), 40);
    wr(3'd0, 20'd1);
    chk("R3 fetch_req when enabled", 32'(fetch_req), 1);
    pulse(0);
    rd(3'd1, v); chk("R3 fetch subtracts 8", 32'(v), 32);
    wr(3'd1, 20'd16, 1'b1);
    rd(3'd1, v); chk("R3 write plus fetch", 32'(v), 40);
    for (int i = 0; i < 5; i++) pulse(0);
    rd(3'd1, v); chk("R3 drained", 32'(v), 0);
    chk("R3 fetch_req low at zero", 32'(fetch_req), 0);
    pulse(0);
    rd(3'd1, v); chk("R3 fetch ignored below 8", 32'(v), 0);
    rd(3'd2, v); chk("R3 no cause from drain", 32'(v), 0);
  endtask

  task automatic t_overflow();
    logic [CNT_W-1:0] v;
    wr(3'd1, 20'hFFFF8);
    chk("R4 no overflow at top", 32'(q_enable), 1);
    wr(3'd1, 20'h10);
    rd(3'd2, v); chk("R4 overflow cause", 32'(v), 32'h2);
    chk("R7 overflow stops queue", 32'(q_enable), 0);
    rd(3'd1, v); chk("R4 wrapped count", 32'(v), 8);
    wr(3'd1, 20'hFFFF8);
    rd(3'd1, v); chk("R4 recovery to zero", 32'(v), 0);
    wr(3'd2, 20'h2);
    rd(3'd2, v); chk("R5 w1c overflow cause", 32'(v), 0);
  endtask

  task automatic t_errors();
    logic [CNT_W-1:0] v;
    wr(3'd0, 20'd1); pulse(1);
    rd(3'd2, v); chk("R5 read error cause", 32'(v), 32'h4);
    chk("R7 read error stops", 32'(q_enable), 0);
    wr(3'd2, 20'h4); wr(3'd0, 20'd1); pulse(2);
    rd(3'd3, v); chk("R5 write error cause", 32'(v), 32'h8);
    chk("R7 write error stops", 32'(q_enable), 0);
    wr(3'd2, 20'h8); wr(3'd0, 20'd1); pulse(3);
    rd(3'd2, v); chk("R5 engine error cause", 32'(v), 32'h10);
    chk("R7 engine error keeps queue", 32'(q_enable), 1);
    wr(3'd2, 20'h10);
    wr(3'd3, 20'h1);
    chk("R7 sw mailbox set keeps queue", 32'(q_enable), 1);
    wr(3'd3, 20'h8);
    rd(3'd2, v); chk("R5 sw set accumulates", 32'(v), 32'h9);
    chk("R7 sw set of write error stops", 32'(q_enable), 0);
    wr(3'd2, 20'h1);
    rd(3'd2, v); chk("R5 partial w1c", 32'(v), 32'h8);
    wr(3'd2, 20'h8);
  endtask

  task automatic t_continue();
    logic [CNT_W-1:0] v;
    wr(3'd0, 20'd3); pulse(1);
    chk("R8 read error recorded, queue kept", 32'(q_enable), 1);
    wr(3'd3, 20'h2);
    rd(3'd2, v); chk("R8 causes recorded", 32'(v), 32'h6);
    rd(3'd0, v); chk("R8 control unchanged", 32'(v), 3);
    wr(3'd2, 20'h1F); wr(3'd0, 20'd0);
  endtask

  task automatic t_mbox_irq();
    logic [CNT_W-1:0] v;
    wr(3'd6, 20'h0);
    rd(3'd2, v); chk("R9 mailbox cause", 32'(v), 32'h1);
    chk("R10 no irq without enable", 32'(irq), 0);
    wr(3'd4, 20'h4);
    rd(3'd4, v); chk("R6 enable via set alias", 32'(v), 32'h4);
    rd(3'd5, v); chk("R6 enable via clear alias", 32'(v), 32'h4);
    wr(3'd3, 20'h4);
    chk("R10 irq asserted", 32'(irq), 1);
    repeat (3) @(negedge clk);
    chk("R10 irq holds level", 32'(irq), 1);
    wr(3'd4, 20'h2); wr(3'd5, 20'h4);
    rd(3'd4, v); chk("R6 w1s then w1c", 32'(v), 32'h2);
    chk("R10 irq off after enable cleared", 32'(irq), 0);
    wr(3'd2, 20'h5);
    rd(3'd2, v); chk("R5 all cleared", 32'(v), 0);
  endtask

  task automatic t_priority();
    logic [CNT_W-1:0] v;
    wr(3'd2, 20'h4, 1'b0, 1'b1);
    rd(3'd2, v); chk("R11 hw set beats sw clear", 32'(v), 32'h4);
    wr(3'd2, 20'h4);
    rd(3'd2, v); chk("R11 later clear works", 32'(v), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_doorbell();
    t_overflow();
    t_errors();
    t_continue();
    t_mbox_irq();
    t_priority();
    finish_run();
  end

  initial begin
    #1000000;
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule